// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block collects the event flags of a memory-mapped I2C master controller and turns them into one level interrupt and two DMA request lines. The transfer engine reports events as single-cycle set pulses (and, for the data-ready flags, single-cycle clear pulses). Each pulse lands in a 16-bit status register. Software reaches the block through a plain register port with four selectable registers. It sets a 6-bit interrupt enable mask, acknowledges events, and picks which transfer directions are served by DMA.

A vector register lets an interrupt handler fetch and acknowledge work in one access. Reading it returns the 1-based position of the lowest pending enabled event and clears that event in the same cycle. Turning on DMA for a direction takes the matching ready flag away from the interrupt: the enable bit for that flag is cleared as a side effect of the configuration write.

The register select codes are 0 for status, 1 for enable mask, 2 for vector and 3 for DMA configuration. Read data is combinational and valid in the cycle that `reg_rd` is high. All state changes take effect at the next rising clock edge. The outputs are decoded combinationally from the stored state.

Top module: `isv_unit`

## Requirements
- R1: Reset clears status, enable mask and DMA configuration, so `irq`, `dma_rx_req` and `dma_tx_req` are low and status, enable and configuration all read as zero.
- R2: `irq` is high exactly when some status bit in positions 0..5 is set together with the same bit of the enable mask.
- R3: A read with select 2 returns k+1, where k is the lowest position at which both status and enable are set, or 0 when there is none. A non-zero result clears status bit k at the next edge and leaves the other bits unchanged.
- R4: When a set pulse and any clear source (vector read, software write, hardware clear) hit the same status bit in one cycle, the bit ends up set.
- R5: A write with select 0 clears the status bits where the written value has a one, but only for bits 0, 1, 2 and 5. Every other status bit, including receive-ready (bit 3) and transmit-ready (bit 4), is left unchanged.
- R6: A pulse on `evt_clr[i]` clears status bit i at the next edge. This is the only way to drop bits 3 and 4 when they are not enabled.
- R7: A write with select 1 stores the low 6 bits of `reg_wdata` as the enable mask. Upper bits are discarded, and a read with select 1 returns the mask zero-extended.
- R8: A write with select 3 stores only bits 15 and 7 of `reg_wdata`. A one in bit 15 clears enable bit 3, and a one in bit 7 clears enable bit 4, in the same edge.
- R9: `dma_rx_req` equals status bit 3 while configuration bit 15 is set and is low otherwise. `dma_tx_req` equals status bit 4 while configuration bit 7 is set and is low otherwise.
- R10: A read with select 0 returns the status with bit 12 replaced by `bus_busy`. Status bit 12 is never stored, so a set pulse on it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 DMA config |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, zero when `reg_rd` is low |
| evt_set | input | 16 | One-cycle set pulses from the transfer engine, one per status bit |
| evt_clr | input | 16 | One-cycle clear pulses from the transfer engine, one per status bit |
| bus_busy | input | 1 | Live bus-busy flag, reported in status bit 12 |
| irq | output | 1 | Level interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, since one register access is one operation. They also assume that set and clear pulses may coincide on any bit. The stimulus table drives at most one of the two strobes per step and releases it after one edge. Steps that deliberately overlap a set pulse with a vector read or a hardware clear are included, so the set-priority properties see real activity.

// File: rtl/isv_pkg.sv
package isv_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_DMACFG = 2'd3
  } isv_sel_e;
endpackage

// File: rtl/isv_status_reg.sv
module isv_status_reg #(
  parameter int          W        = 16,
  parameter logic [W-1:0] W1C_MASK = 16'h0027
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic         sw_wr_i,
  input  logic [W-1:0] sw_wdata_i,
  input  logic [W-1:0] vec_clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] sw_clr;
  assign sw_clr = sw_wr_i ? (sw_wdata_i & W1C_MASK) : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     q <= 1'b0;
      else if (set_i[i])                              q <= 1'b1;
      else if (hw_clr_i[i] | sw_clr[i] | vec_clr_i[i]) q <= 1'b0;
    end
    assign status_o[i] = q;

    // R4: a set pulse wins over every clear source in the same cycle
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> status_o[i]);

    if (!W1C_MASK[i]) begin : g_protected
      // R5: software writes cannot touch bits outside the clearable set
      a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !hw_clr_i[i] && !vec_clr_i[i])
          |=> status_o[i] == ($past(status_o[i]) | $past(set_i[i])));
    end
  end
endmodule

// File: rtl/isv_vector.sv
module isv_vector #(
  parameter int MASK_W = 6,
  parameter int W      = 16,
  localparam int VEC_W = $clog2(MASK_W + 1)
) (
  input  logic [MASK_W-1:0] status_i,
  input  logic [MASK_W-1:0] enable_i,
  output logic              any_o,
  output logic [VEC_W-1:0]  index_o,
  output logic [W-1:0]      clr_onehot_o
);
  logic [MASK_W-1:0] pend;
  assign pend  = status_i & enable_i;
  assign any_o = |pend;

  always_comb begin
    index_o = '0;
    for (int k = MASK_W - 1; k >= 0; k--) begin
      if (pend[k]) index_o = VEC_W'(k + 1);
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_clr
    if (k < MASK_W) begin : g_live
      assign clr_onehot_o[k] = (index_o == VEC_W'(k + 1));
    end else begin : g_none
      assign clr_onehot_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/isv_ctrl_regs.sv
module isv_ctrl_regs #(
  parameter int W          = 16,
  parameter int MASK_W     = 6,
  parameter int RX_CFG_BIT = 15,
  parameter int TX_CFG_BIT = 7,
  parameter int RX_BIT     = 3,
  parameter int TX_BIT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask_i,
  input  logic              wr_cfg_i,
  input  logic [W-1:0]      wdata_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [W-1:0]      cfg_o
);
  localparam logic [W-1:0] CFG_KEEP = (W'(1) << RX_CFG_BIT) | (W'(1) << TX_CFG_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      cfg_o  <= '0;
    end else if (wr_mask_i) begin
      mask_o <= wdata_i[MASK_W-1:0];
    end else if (wr_cfg_i) begin
      cfg_o <= wdata_i & CFG_KEEP;
      if (wdata_i[RX_CFG_BIT]) mask_o[RX_BIT] <= 1'b0;
      if (wdata_i[TX_CFG_BIT]) mask_o[TX_BIT] <= 1'b0;
    end
  end

  // R8: turning on a DMA direction removes the matching interrupt enable
  a_r8_rx_cfg_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg_i && wdata_i[RX_CFG_BIT]) |=> !mask_o[RX_BIT]);
  a_r8_tx_cfg_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg_i && wdata_i[TX_CFG_BIT]) |=> !mask_o[TX_BIT]);
  // R7: the mask only moves on a register write
  a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mask_i && !wr_cfg_i) |=> $stable(mask_o));
endmodule

// File: rtl/isv_unit.sv
module isv_unit #(
  parameter int W          = 16,
  parameter int MASK_W     = 6,
  parameter int RX_BIT     = 3,
  parameter int TX_BIT     = 4,
  parameter int BUSY_BIT   = 12,
  parameter int RX_CFG_BIT = 15,
  parameter int TX_CFG_BIT = 7,
  parameter logic [W-1:0] W1C_MASK = 16'h0027
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_sel,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] evt_clr,
  input  logic         bus_busy,
  output logic         irq,
  output logic         dma_rx_req,
  output logic         dma_tx_req
);
  import isv_pkg::*;

  localparam int VEC_W = $clog2(MASK_W + 1);
  localparam logic [W-1:0] STORE_MASK = ~(W'(1) << BUSY_BIT);

  isv_sel_e sel;
  assign sel = isv_sel_e'(reg_sel);

  logic [W-1:0]      status;
  logic [MASK_W-1:0] mask;
  logic [W-1:0]      cfg;
  logic              any_pend;
  logic [VEC_W-1:0]  vec_idx;
  logic [W-1:0]      vec_onehot;
  logic [W-1:0]      vec_clr;
  logic [W-1:0]      set_eff;

  assign set_eff = evt_set & STORE_MASK;
  assign vec_clr = (reg_rd && sel == SEL_VECTOR) ? vec_onehot : '0;

  isv_status_reg #(.W(W), .W1C_MASK(W1C_MASK)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_eff),
    .hw_clr_i   (evt_clr),
    .sw_wr_i    (reg_wr && sel == SEL_STATUS),
    .sw_wdata_i (reg_wdata),
    .vec_clr_i  (vec_clr),
    .status_o   (status)
  );

  isv_vector #(.MASK_W(MASK_W), .W(W)) u_vector (
    .status_i     (status[MASK_W-1:0]),
    .enable_i     (mask),
    .any_o        (any_pend),
    .index_o      (vec_idx),
    .clr_onehot_o (vec_onehot)
  );

  isv_ctrl_regs #(
    .W(W), .MASK_W(MASK_W), .RX_CFG_BIT(RX_CFG_BIT), .TX_CFG_BIT(TX_CFG_BIT),
    .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask_i (reg_wr && sel == SEL_ENABLE),
    .wr_cfg_i  (reg_wr && sel == SEL_DMACFG),
    .wdata_i   (reg_wdata),
    .mask_o    (mask),
    .cfg_o     (cfg)
  );

  assign irq        = any_pend;
  assign dma_rx_req = cfg[RX_CFG_BIT] & status[RX_BIT];
  assign dma_tx_req = cfg[TX_CFG_BIT] & status[TX_BIT];

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (sel)
        SEL_STATUS: begin
          reg_rdata           = status;
          reg_rdata[BUSY_BIT] = bus_busy;
        end
        SEL_ENABLE: reg_rdata = W'(mask);
        SEL_VECTOR: reg_rdata = W'(vec_idx);
        SEL_DMACFG: reg_rdata = cfg;
      endcase
    end
  end

  // input assumption: one access per cycle
  a_in_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  // R3: a non-zero vector read leaves the reported bit clear unless re-set
  a_r3_vector_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == SEL_VECTOR && vec_idx != '0 && (set_eff & vec_onehot) == '0)
      |=> (status & $past(vec_onehot)) == '0);
  // R2: the interrupt can only rise after an event or a mask/config write
  a_r2_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|evt_set) || $past(reg_wr)));
  // R9: a DMA request needs its direction enabled
  a_r9_rx_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> cfg[RX_CFG_BIT]);
  a_r9_tx_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> cfg[TX_CFG_BIT]);
  // R10: the busy position is never held in the status store
  a_r10_busy_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    !status[BUSY_BIT]);
endmodule

// File: tb/isv_unit_test.sv
`timescale 1ns/1ps
module isv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [15:0] evt_set = '0, evt_clr = '0;
  logic        bus_busy = 1'b0;
  logic        irq, dma_rx_req, dma_tx_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isv_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set), .evt_clr(evt_clr),
    .bus_busy(bus_busy), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;     // 0 idle, 1 write, 2 read
    logic [1:0]  sel;
    logic [15:0] wdata;
    logic [15:0] set;
    logic [15:0] clr;
    logic        busy;
    logic [15:0] exp_rd;
    logic        exp_irq;
    logic        exp_rx;
    logic        exp_tx;
  } step_t;

  localparam int NSTEPS = 24;
  localparam step_t STEPS [NSTEPS] = '{
    '{8'd7,  2'd1, 2'd1, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R7 mask write
    '{8'd7,  2'd2, 2'd1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h003F, 1'b0, 1'b0, 1'b0}, // R7 mask read
    '{8'd2,  2'd0, 2'd0, 16'h0000, 16'h0004, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R2
    '{8'd2,  2'd0, 2'd0, 16'h0000, 16'h0020, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R2
    '{8'd3,  2'd2, 2'd2, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b0}, // R3 lowest
    '{8'd3,  2'd2, 2'd2, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0006, 1'b0, 1'b0, 1'b0}, // R3 next
    '{8'd3,  2'd2, 2'd2, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3 none
    '{8'd2,  2'd0, 2'd0, 16'h0000, 16'h8C1A, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R2
    '{8'd5,  2'd1, 2'd0, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R5 w1c
    '{8'd10, 2'd2, 2'd0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h9C18, 1'b1, 1'b0, 1'b0}, // R10 busy
    '{8'd8,  2'd1, 2'd3, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1}, // R8 R9
    '{8'd8,  2'd2, 2'd3, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h8080, 1'b0, 1'b1, 1'b1}, // R8
    '{8'd8,  2'd2, 2'd1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0027, 1'b0, 1'b1, 1'b1}, // R8
    '{8'd6,  2'd0, 2'd0, 16'h0000, 16'h0000, 16'h0008, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1}, // R6
    '{8'd9,  2'd1, 2'd3, 16'h0080, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1}, // R9
    '{8'd9,  2'd1, 2'd3, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R9
    '{8'd4,  2'd0, 2'd0, 16'h0000, 16'h0010, 16'h0010, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R4
    '{8'd4,  2'd2, 2'd0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h8C10, 1'b0, 1'b0, 1'b0}, // R4
    '{8'd10, 2'd0, 2'd0, 16'h0000, 16'h1000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R10
    '{8'd10, 2'd2, 2'd0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h8C10, 1'b0, 1'b0, 1'b0}, // R10
    '{8'd7,  2'd1, 2'd1, 16'h0002, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R7
    '{8'd2,  2'd0, 2'd0, 16'h0000, 16'h0002, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R2
    '{8'd4,  2'd2, 2'd2, 16'h0000, 16'h0002, 16'h0000, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0}, // R4
    '{8'd3,  2'd2, 2'd2, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0002, 1'b0, 1'b0, 1'b0}  // R3
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic check_quiet(input string tag);
    logic [15:0] v;
    check({tag, " irq"}, {15'd0, irq}, 16'd0);
    check({tag, " dma_rx"}, {15'd0, dma_rx_req}, 16'd0);
    check({tag, " dma_tx"}, {15'd0, dma_tx_req}, 16'd0);
    read_reg(2'd0, v); check({tag, " status"}, v, 16'h0000);
    read_reg(2'd1, v); check({tag, " enable"}, v, 16'h0000);
    read_reg(2'd3, v); check({tag, " dmacfg"}, v, 16'h0000);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_quiet("R1 reset");

    for (int i = 0; i < NSTEPS; i++) begin
      step_t s;
      string tag;
      s = STEPS[i];
      tag = $sformatf("R%0d step%0d", s.req, i);
      @(negedge clk);
      reg_sel = s.sel; reg_wdata = s.wdata; evt_set = s.set; evt_clr = s.clr;
      bus_busy = s.busy; reg_wr = (s.op == 2'd1); reg_rd = (s.op == 2'd2);
      #1;
      if (s.op == 2'd2) check({tag, " rdata"}, reg_rdata, s.exp_rd);
      @(posedge clk);
      #1;
      reg_wr = 1'b0; reg_rd = 1'b0; evt_set = '0; evt_clr = '0; bus_busy = 1'b0;
      check({tag, " irq"}, {15'd0, irq}, {15'd0, s.exp_irq});
      check({tag, " dma_rx"}, {15'd0, dma_rx_req}, {15'd0, s.exp_rx});
      check({tag, " dma_tx"}, {15'd0, dma_tx_req}, {15'd0, s.exp_tx});
    end

    // R1: reset in the middle of activity
    @(negedge clk);
    reg_sel = 2'd3; reg_wdata = 16'h8080; reg_wr = 1'b1; evt_set = 16'h0018;
    @(posedge clk); #1 reg_wr = 1'b0; evt_set = '0;
    check("R9 pre-reset rx", {15'd0, dma_rx_req}, 16'd1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    check_quiet("R1 mid-run reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule